// File: doc/BRIEF.md
# Radio Reset and Ready Sequencer

This block owns the active-low reset line of an attached radio transceiver. The line is open-drain: the block either pulls it low through the pad output enable or leaves it floating, and it reads the line back through the pad input. After its own reset the block waits out the transceiver's power-on reset time. It then samples the line and reports whether the device came up.

A one-cycle start request issued while the block is idle launches a commanded reset. The line is held low for a programmed time and then released, never driven high. The block waits for the device to boot and takes the synchronised line level at the end of that wait as the ready verdict. All three durations are given in microseconds and turned into cycle counts from a clock-frequency parameter in kHz, with the result rounded up.

Top module: `radio_rst_seq`

## Requirements
- R1: While the synchronous reset is high and in the cycle after it, busy_o is 1 and pad_oe_o, done_o and ready_o are 0.
- R2: After reset is released the power-on wait lasts ceil(CLK_KHZ*POR_US/1000) cycles with busy_o high. done_o then pulses, and ready_o takes the line level.
- R3: A start_i sampled high while idle makes pad_oe_o go to 1 (line pulled low) from the next cycle for exactly ceil(CLK_KHZ*PULSE_US/1000) cycles.
- R4: After the low pulse pad_oe_o is 0 (line released) for a boot wait of exactly ceil(CLK_KHZ*BOOT_US/1000) cycles. done_o follows at the end of that wait.
- R5: At the end of each wait ready_o becomes 1 if the line, seen through a two-flop synchroniser, reads 1, and 0 otherwise.
- R6: start_i is ignored while busy_o is 1, including in the last cycle of a wait. It neither restarts nor stretches the sequence.
- R7: done_o is high for exactly one cycle per sequence. ready_o holds its value until the next accepted start clears it.
- R8: A start_i in the same cycle that done_o is high is accepted and begins a new low pulse.
- R9: busy_o is 1 from the first cycle of the low pulse through the boot wait, and 0 in the cycle done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to reset the transceiver |
| pad_i | input | 1 | Read-back level of the reset line |
| pad_oe_o | output | 1 | 1 pulls the line low, 0 releases it |
| busy_o | output | 1 | A wait or pulse is in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ready_o | output | 1 | Device was seen up at the last check |

## Verification
Two events can fall in the same cycle: a start request and the end of a sequence. The bench drives start_i into the final edge of a boot wait and checks that it is dropped, with no second low pulse and unchanged counts. It also drives start_i in the cycle done_o is high and checks that a full new low pulse follows and that ready_o is cleared.

// File: rtl/rr_pkg.sv
package rr_pkg;

   typedef enum logic [1:0] {
      RR_POR   = 2'd0,
      RR_IDLE  = 2'd1,
      RR_PULSE = 2'd2,
      RR_BOOT  = 2'd3
   } rr_state_e;

   // microseconds to clock cycles, rounded up so minimum times hold
   function automatic int unsigned rr_cycles(input int unsigned khz, input int unsigned us);
      return (khz * us + 999) / 1000;
   endfunction

endpackage

// File: rtl/rr_sync.sv
module rr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rr_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (rst) stg_q <= '0;
      else     stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rr_timer.sv
module rr_timer #(
   parameter int unsigned W       = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= W'(RST_VAL);
      else if (load_i)        cnt_q <= val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R4: a running wait loses exactly one count per cycle
   p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/radio_rst_seq.sv
module radio_rst_seq
   import rr_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 50000,
   parameter int unsigned POR_US      = 10000,
   parameter int unsigned PULSE_US    = 200,
   parameter int unsigned BOOT_US     = 6000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic pad_i,
   output logic pad_oe_o,
   output logic busy_o,
   output logic done_o,
   output logic ready_o
);

   localparam int unsigned POR_CYC   = rr_cycles(CLK_KHZ, POR_US);
   localparam int unsigned PULSE_CYC = rr_cycles(CLK_KHZ, PULSE_US);
   localparam int unsigned BOOT_CYC  = rr_cycles(CLK_KHZ, BOOT_US);
   localparam int unsigned MAX_A     = (POR_CYC > PULSE_CYC) ? POR_CYC : PULSE_CYC;
   localparam int unsigned MAX_CYC   = (MAX_A > BOOT_CYC) ? MAX_A : BOOT_CYC;
   localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

   generate
      if (PULSE_US < 100) begin : g_bad_pulse
         $error("low pulse shorter than 100 us");
      end
      if (BOOT_US < 5000) begin : g_bad_boot
         $error("boot wait shorter than 5 ms");
      end
      if (POR_CYC < 1 || PULSE_CYC < 1 || BOOT_CYC < 1) begin : g_bad_clk
         $error("clock too slow for the programmed times");
      end
   endgenerate

   rr_state_e        state_q, state_d;
   logic             t_load, t_zero, line_q, accept, finish;
   logic [CNT_W-1:0] t_val;

   rr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pad_i),
      .q_o (line_q)
   );

   rr_timer #(.W(CNT_W), .RST_VAL(POR_CYC - 1)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .load_i (t_load),
      .val_i  (t_val),
      .zero_o (t_zero)
   );

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      unique case (state_q)
         RR_POR:   if (t_zero) state_d = RR_IDLE;
         RR_IDLE:  if (start_i) begin
                      state_d = RR_PULSE;
                      t_load  = 1'b1;
                      t_val   = CNT_W'(PULSE_CYC - 1);
                   end
         RR_PULSE: if (t_zero) begin
                      state_d = RR_BOOT;
                      t_load  = 1'b1;
                      t_val   = CNT_W'(BOOT_CYC - 1);
                   end
         RR_BOOT:  if (t_zero) state_d = RR_IDLE;
         default:  state_d = RR_POR;
      endcase
   end

   assign accept = (state_q == RR_IDLE) && start_i;
   assign finish = ((state_q == RR_POR) || (state_q == RR_BOOT)) && t_zero;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RR_POR;
         done_o  <= 1'b0;
         ready_o <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= finish;
         if (finish)      ready_o <= line_q;
         else if (accept) ready_o <= 1'b0;
      end
   end

   assign pad_oe_o = (state_q == RR_PULSE);
   assign busy_o   = (state_q != RR_IDLE);

   // R3: the line is only pulled low after an accepted start
   p_oe_after_start_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(pad_oe_o) |-> ($past(start_i) && !$past(busy_o)));

   // R7: end-of-sequence pulse lasts one cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R7: a new sequence starts with ready cleared
   p_ready_cleared_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> !ready_o);

   // R5: ready moves only at a verdict or a start
   p_ready_moves_r5: assert property (@(posedge clk) disable iff (rst)
      !$stable(ready_o) |-> (done_o || busy_o));

   // R9: the verdict cycle is never busy
   p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
      (done_o && !$past(done_o)) |-> !busy_o || $past(start_i));

endmodule

// File: tb/radio_rst_seq_test.sv
module radio_rst_seq_test;

   localparam int CLK_KHZ   = 50;
   localparam int POR_CYC   = 500;
   localparam int PULSE_CYC = 10;
   localparam int BOOT_CYC  = 300;
   localparam int NVEC      = 5;
   localparam int NONE      = 1023;

   // {device_up, expected_ready, stray start index[9:0]}
   localparam logic [11:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 10'd1023},
      {1'b0, 1'b0, 10'd1023},
      {1'b1, 1'b1, 10'd3},
      {1'b1, 1'b1, 10'd150},
      {1'b1, 1'b1, 10'd309}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_i = 1'b0;
   logic dev_up = 1'b1;
   logic pad_i, pad_oe_o, busy_o, done_o, ready_o;
   int   total = 0;
   int   bad = 0;
   int   cyc = 0;

   assign pad_i = pad_oe_o ? 1'b0 : dev_up;

   radio_rst_seq #(.CLK_KHZ(CLK_KHZ)) uut (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .pad_i    (pad_i),
      .pad_oe_o (pad_oe_o),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .ready_o  (ready_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // starts at a negedge, returns at the negedge where done_o is high
   task automatic run_seq(input int spur, output int n_oe, output int n_boot,
                          output int n_idle, output bit r0);
      n_oe = 0; n_boot = 0; n_idle = 0; r0 = 1'b1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      r0 = ready_o;
      for (int k = 0; k < 2000; k++) begin
         if (done_o) break;
         if (!busy_o) n_idle++;
         if (pad_oe_o) n_oe++; else n_boot++;
         start_i = (k == spur);
         @(negedge clk);
      end
      start_i = 1'b0;
   endtask

   task automatic count_por(output int n);
      n = 0;
      for (int k = 0; k < 2000; k++) begin
         if (done_o) break;
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n_oe, n_boot, n_idle, n;
      bit r0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy_o === 1'b1, "R1 busy", busy_o, 1);
      chk(pad_oe_o === 1'b0, "R1 oe", pad_oe_o, 0);
      chk(done_o === 1'b0 && ready_o === 1'b0, "R1 done/ready", {done_o, ready_o}, 0);
      rst = 1'b0;
      start_i = 1'b1;              // R6: ignored during power-on wait
      count_por(n);
      start_i = 1'b0;
      chk(n == POR_CYC, "R2 power-on wait", n, POR_CYC);
      chk(ready_o === 1'b1, "R2 ready after power-on", ready_o, 1);
      chk(busy_o === 1'b0, "R9 idle at done", busy_o, 0);
      @(negedge clk);
      chk(done_o === 1'b0 && ready_o === 1'b1, "R7 done one cycle, ready held",
          {done_o, ready_o}, 1);

      for (int v = 0; v < NVEC; v++) begin
         dev_up = VEC[v][11];
         run_seq(int'(VEC[v][9:0]), n_oe, n_boot, n_idle, r0);
         chk(n_oe == PULSE_CYC, "R3 low pulse length", n_oe, PULSE_CYC);
         chk(n_boot == BOOT_CYC, "R4 boot wait / R6 stray start", n_boot, BOOT_CYC);
         chk(ready_o === VEC[v][10], "R5 ready verdict", ready_o, VEC[v][10]);
         chk(r0 === 1'b0 && n_idle == 0, "R7 R9 ready cleared, busy held",
             {r0, n_idle}, 0);
         @(negedge clk);
         chk(done_o === 1'b0 && pad_oe_o === 1'b0 && ready_o === VEC[v][10],
             "R7 after done", {done_o, pad_oe_o, ready_o}, VEC[v][10]);
      end

      // R8: start in the done cycle is accepted
      dev_up = 1'b1;
      run_seq(NONE, n_oe, n_boot, n_idle, r0);
      run_seq(NONE, n_oe, n_boot, n_idle, r0);
      chk(n_oe == PULSE_CYC && n_boot == BOOT_CYC, "R8 back-to-back",
          n_oe + n_boot, PULSE_CYC + BOOT_CYC);
      chk(r0 === 1'b0, "R8 ready cleared", r0, 0);
      @(negedge clk);

      // reset in the middle of a pulse, device stays down
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      chk(pad_oe_o === 1'b1, "R3 pulling low", pad_oe_o, 1);
      rst = 1'b1;
      dev_up = 1'b0;
      @(negedge clk);
      chk(pad_oe_o === 1'b0 && busy_o === 1'b1 && ready_o === 1'b0, "R1 reset mid-pulse",
          {pad_oe_o, busy_o, ready_o}, 2);
      rst = 1'b0;
      count_por(n);
      chk(n == POR_CYC, "R2 second power-on wait", n, POR_CYC);
      chk(ready_o === 1'b0, "R5 device down", ready_o, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule